// File: doc/BRIEF.md
# Scaled-Index Effective Address Generator

This block forms a 64-bit operand location from four pre-decoded pieces: a signed 32-bit displacement, an optional base value, an optional index value and a scale selector. The result is displacement plus base plus the index multiplied by 1, 2, 4 or 8. Every addition wraps modulo 2^64. Absent terms contribute zero. This one datapath therefore serves five forms:

- constant address only
- base only
- base plus offset
- scaled index
- scaled index plus offset

Each accepted request is a single cycle with `in_valid` high. One cycle later the result appears on one of two outputs. In memory mode it goes to `mem_addr` with `mem_req` raised. In address-arithmetic mode it goes to `lea_data` with `lea_valid` raised, and no memory request is made. The arithmetic mode has a full 64-bit variant and a 32-bit variant. The 32-bit variant keeps the low half of the sum and clears the upper half.

A small state register records which output the current cycle presents. Its states are:

- `ST_IDLE`: nothing is presented.
- `ST_MEM`: an address is presented.
- `ST_LEA64`: a 64-bit data value is presented.
- `ST_LEA32`: a 32-bit data value is presented.

Transition rules:

- Each cycle the next state is chosen from `in_valid` and `op_mode`.
- If `in_valid` is low, the next state is `ST_IDLE`.
- Otherwise the mode selects the state: mode 0 gives `ST_MEM`, mode 1 gives `ST_LEA64`, mode 2 gives `ST_LEA32`.
- Mode 3 also returns to `ST_IDLE`.

Top module: `ea_scaled_gen`

## Requirements
- R1: One cycle after an accepted request, the presented result equals sext(disp) + base term + index term, wrapped to 64 bits.
- R2: With `scale_given`=1, the index term is `index_val` shifted left by `scale_sh` (0..3), which multiplies it by 1, 2, 4 or 8.
- R3: With `has_base`=0, the base term is zero whatever `base_val` holds.
- R4: With `has_index`=0, the index term is zero whatever `index_val` and `scale_sh` hold.
- R5: With `has_index`=1 and `scale_given`=0, the index is added unscaled (factor 1), ignoring `scale_sh`.
- R6: `disp` is two's-complement and sign-extended, so negative offsets subtract.
- R7: `op_mode`=2'b00 (memory) gives `mem_req`=1, `mem_addr`=result, `lea_valid`=0 and `lea_data`=0 on the next cycle.
- R8: `op_mode`=2'b01 (64-bit arithmetic) gives `lea_valid`=1, `lea_data`=result, `mem_req`=0 and `mem_addr`=0 on the next cycle.
- R9: `op_mode`=2'b10 (32-bit arithmetic) gives `lea_valid`=1 and `lea_data`={32'h0, result[31:0]}.
- R10: During reset, and on the cycle after `in_valid`=0, all four outputs are zero.
- R11: `op_mode`=2'b11 is reserved. A request in that mode leaves all outputs zero on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request accepted this cycle |
| op_mode | input | 2 | 0 memory, 1 arithmetic 64-bit, 2 arithmetic 32-bit, 3 reserved |
| disp | input | 32 | Signed displacement |
| has_base | input | 1 | Base term present |
| base_val | input | 64 | Base register value |
| has_index | input | 1 | Index term present |
| index_val | input | 64 | Index register value |
| scale_given | input | 1 | Explicit scale present |
| scale_sh | input | 2 | Scale as shift amount (factor 1, 2, 4, 8) |
| mem_req | output | 1 | Memory address presented |
| mem_addr | output | 64 | Effective address |
| lea_valid | output | 1 | Arithmetic result presented |
| lea_data | output | 64 | Arithmetic result |

## Verification
Every result is due exactly one clock edge after the cycle in which its request (or its idle cycle) was driven. This includes the zeros that follow an idle or reserved cycle. The driver pushes one expected item per driven cycle, including idle ones. The monitor pops one item shortly after every rising edge, so each comparison lines up with the single register stage and any shift in latency shows up as a mismatch. Back-to-back requests in alternating modes confirm that each result lands on the correct output in the correct cycle.

// File: rtl/ea_scaled_pkg.sv
package ea_scaled_pkg;
    localparam int EA_W   = 64;
    localparam int DISP_W = 32;
    localparam int SH_W   = 2;
    localparam int HALF_W = EA_W / 2;

    typedef enum logic [1:0] {
        MODE_MEM   = 2'b00,
        MODE_LEA64 = 2'b01,
        MODE_LEA32 = 2'b10,
        MODE_RSVD  = 2'b11
    } ea_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_MEM,
        ST_LEA64,
        ST_LEA32
    } ea_state_e;
endpackage

// File: rtl/ea_operand_prep.sv
module ea_operand_prep #(
    parameter int ADDR_W = 64,
    parameter int DSP_W  = 32,
    parameter int SHW    = 2
) (
    input  logic [DSP_W-1:0]  disp,
    input  logic              has_base,
    input  logic [ADDR_W-1:0] base_val,
    input  logic              has_index,
    input  logic [ADDR_W-1:0] index_val,
    input  logic              scale_given,
    input  logic [SHW-1:0]    scale_sh,
    output logic [ADDR_W-1:0] disp_term,
    output logic [ADDR_W-1:0] base_term,
    output logic [ADDR_W-1:0] index_term
);
    localparam int EXT_W = ADDR_W - DSP_W;

    logic [SHW-1:0] eff_sh;

    always_comb begin
        // Sign-extend the displacement to the full address width (R6).
        disp_term  = {{EXT_W{disp[DSP_W-1]}}, disp};
        // An absent base contributes nothing (R3).
        base_term  = has_base ? base_val : '0;
        // With no explicit scale the factor is 1 (R5).
        eff_sh     = scale_given ? scale_sh : '0;
        // An absent index contributes nothing; otherwise shift by the scale (R2, R4).
        index_term = has_index ? (index_val << eff_sh) : '0;
    end
endmodule

// File: rtl/ea_adder3.sv
module ea_adder3 #(
    parameter int ADDR_W = 64
) (
    input  logic [ADDR_W-1:0] a,
    input  logic [ADDR_W-1:0] b,
    input  logic [ADDR_W-1:0] c,
    output logic [ADDR_W-1:0] sum
);
    // Carry-save stage: reduce three operands to a sum vector and a carry vector.
    logic [ADDR_W-1:0] s_vec;
    logic [ADDR_W-1:0] c_vec;

    for (genvar i = 0; i < ADDR_W; i++) begin : g_csa
        assign s_vec[i] = a[i] ^ b[i] ^ c[i];
        if (i + 1 < ADDR_W) begin : g_carry
            assign c_vec[i+1] = (a[i] & b[i]) | (a[i] & c[i]) | (b[i] & c[i]);
        end
    end
    assign c_vec[0] = 1'b0;

    // Final carry-propagate add; the carry out is dropped, so the sum wraps (R1).
    assign sum = s_vec + c_vec;
endmodule

// File: rtl/ea_result_fmt.sv
module ea_result_fmt #(
    parameter int ADDR_W = 64
) (
    input  logic [ADDR_W-1:0] sum,
    input  logic              narrow,
    output logic [ADDR_W-1:0] result
);
    localparam int LOW_W = ADDR_W / 2;

    // In the 32-bit variant keep the low half and clear the upper half (R9).
    always_comb begin
        result = sum;
        if (narrow) begin
            result[ADDR_W-1:LOW_W] = '0;
        end
    end
endmodule

// File: rtl/ea_scaled_gen.sv
module ea_scaled_gen
    import ea_scaled_pkg::*;
#(
    parameter int ADDR_W = EA_W,
    parameter int DSP_W  = DISP_W,
    parameter int SHW    = SH_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [1:0]        op_mode,
    input  logic [DSP_W-1:0]  disp,
    input  logic              has_base,
    input  logic [ADDR_W-1:0] base_val,
    input  logic              has_index,
    input  logic [ADDR_W-1:0] index_val,
    input  logic              scale_given,
    input  logic [SHW-1:0]    scale_sh,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              lea_valid,
    output logic [ADDR_W-1:0] lea_data
);
    localparam int HI_LSB = ADDR_W / 2;

    logic [ADDR_W-1:0] disp_term;
    logic [ADDR_W-1:0] base_term;
    logic [ADDR_W-1:0] index_term;
    logic [ADDR_W-1:0] sum_c;
    logic [ADDR_W-1:0] fmt_c;
    logic [ADDR_W-1:0] result_q;
    ea_state_e         state_q;
    ea_state_e         state_d;
    ea_mode_e          mode_c;

    assign mode_c = ea_mode_e'(op_mode);

    ea_operand_prep #(.ADDR_W(ADDR_W), .DSP_W(DSP_W), .SHW(SHW)) u_prep (
        .disp        (disp),
        .has_base    (has_base),
        .base_val    (base_val),
        .has_index   (has_index),
        .index_val   (index_val),
        .scale_given (scale_given),
        .scale_sh    (scale_sh),
        .disp_term   (disp_term),
        .base_term   (base_term),
        .index_term  (index_term)
    );

    ea_adder3 #(.ADDR_W(ADDR_W)) u_add (
        .a   (disp_term),
        .b   (base_term),
        .c   (index_term),
        .sum (sum_c)
    );

    ea_result_fmt #(.ADDR_W(ADDR_W)) u_fmt (
        .sum    (sum_c),
        .narrow (mode_c == MODE_LEA32),
        .result (fmt_c)
    );

    // Next-state selection: idle unless a request arrives; the reserved mode stays idle (R11).
    always_comb begin
        state_d = ST_IDLE;
        if (in_valid) begin
            unique case (mode_c)
                MODE_MEM:   state_d = ST_MEM;
                MODE_LEA64: state_d = ST_LEA64;
                MODE_LEA32: state_d = ST_LEA32;
                default:    state_d = ST_IDLE;
            endcase
        end
    end

    // State and result registers: one cycle of latency.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            result_q <= '0;
        end else begin
            state_q  <= state_d;
            result_q <= fmt_c;
        end
    end

    // Outputs: each one is driven only in the state it belongs to, otherwise zero.
    always_comb begin
        mem_req   = 1'b0;
        mem_addr  = '0;
        lea_valid = 1'b0;
        lea_data  = '0;
        unique case (state_q)
            ST_MEM: begin
                mem_req  = 1'b1;
                mem_addr = result_q;
            end
            ST_LEA64, ST_LEA32: begin
                lea_valid = 1'b1;
                lea_data  = result_q;
            end
            default: ;
        endcase
    end

    a_r1_addr_is_sum: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && (mode_c == MODE_MEM) |=> mem_addr == $past(sum_c));

    a_r7_mem_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && (mode_c == MODE_MEM) |=> mem_req && !lea_valid && (lea_data == '0));

    a_r8_lea_no_req: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && (mode_c == MODE_LEA64) |=> lea_valid && !mem_req && (lea_data == $past(sum_c)));

    a_r9_upper_clear: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && (mode_c == MODE_LEA32) |=> lea_valid && (lea_data[ADDR_W-1:HI_LSB] == '0));

    a_r10_quiet_after_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !mem_req && !lea_valid && (mem_addr == '0) && (lea_data == '0));

    a_r11_reserved_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && (mode_c == MODE_RSVD) |=> !mem_req && !lea_valid);
endmodule

// File: tb/ea_scaled_gen_bench.sv
module ea_scaled_gen_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [1:0]  op_mode = 2'b00;
    logic [31:0] disp = '0;
    logic        has_base = 1'b0;
    logic [63:0] base_val = '0;
    logic        has_index = 1'b0;
    logic [63:0] index_val = '0;
    logic        scale_given = 1'b0;
    logic [1:0]  scale_sh = '0;
    logic        mem_req;
    logic [63:0] mem_addr;
    logic        lea_valid;
    logic [63:0] lea_data;

    int checks = 0;
    int errors = 0;

    typedef struct {
        logic        req;
        logic [63:0] addr;
        logic        lv;
        logic [63:0] data;
        string       tag;
    } exp_t;

    exp_t sb_q[$];

    always #5 clk = ~clk;

    ea_scaled_gen u_ea_scaled_gen (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_mode(op_mode),
        .disp(disp), .has_base(has_base), .base_val(base_val),
        .has_index(has_index), .index_val(index_val),
        .scale_given(scale_given), .scale_sh(scale_sh),
        .mem_req(mem_req), .mem_addr(mem_addr),
        .lea_valid(lea_valid), .lea_data(lea_data)
    );

    task automatic compare(input exp_t e);
        checks++;
        if (mem_req !== e.req || mem_addr !== e.addr || lea_valid !== e.lv || lea_data !== e.data) begin
            errors++;
            $display("FAIL %s: got req=%0b addr=%h lv=%0b data=%h, expected req=%0b addr=%h lv=%0b data=%h",
                     e.tag, mem_req, mem_addr, lea_valid, lea_data, e.req, e.addr, e.lv, e.data);
        end
    endtask

    // Monitor: pops one expectation per cycle, 2 ns after the rising edge.
    always @(posedge clk) begin
        #2;
        if (sb_q.size() > 0) compare(sb_q.pop_front());
    end

    // Driver: applies one cycle of stimulus and pushes its expected result.
    task automatic drive(input logic v, input logic [1:0] m, input logic [31:0] d,
                         input logic hb, input logic [63:0] bv,
                         input logic hi, input logic [63:0] iv,
                         input logic sg, input logic [1:0] sh, input string tag);
        exp_t e;
        logic [63:0] s;
        @(negedge clk);
        in_valid = v; op_mode = m; disp = d; has_base = hb; base_val = bv;
        has_index = hi; index_val = iv; scale_given = sg; scale_sh = sh;
        s = {{32{d[31]}}, d} + (hb ? bv : 64'h0) + (hi ? (iv << (sg ? sh : 2'd0)) : 64'h0);
        e = '{req: 1'b0, addr: 64'h0, lv: 1'b0, data: 64'h0, tag: tag};
        if (v) begin
            if (m == 2'b00) begin e.req = 1'b1; e.addr = s; end
            else if (m == 2'b01) begin e.lv = 1'b1; e.data = s; end
            else if (m == 2'b10) begin e.lv = 1'b1; e.data = {32'h0, s[31:0]}; end
        end
        sb_q.push_back(e);
    endtask

    initial begin
        fork
            begin
                repeat (3) @(posedge clk);
                #2;
                compare('{req: 1'b0, addr: 64'h0, lv: 1'b0, data: 64'h0, tag: "R10 reset"});
                @(negedge clk);
                rst_n = 1'b1;
                // R7 R3 R4: constant address only
                drive(1, 2'b00, 32'h0000_1000, 0, 64'hDEAD, 0, 64'hBEEF, 1, 2'd3, "R7 R3 R4 direct");
                // R3: base only
                drive(1, 2'b00, 32'h0, 1, 64'h200, 0, 64'h0, 0, 2'd0, "R3 base only");
                // R1: base plus offset
                drive(1, 2'b00, 32'h8, 1, 64'h200, 0, 64'h0, 0, 2'd0, "R1 base+disp");
                // R2: each scale factor
                drive(1, 2'b00, 32'h0, 1, 64'h200, 1, 64'h2, 1, 2'd2, "R2 scale x4");
                drive(1, 2'b00, 32'h0, 1, 64'h200, 1, 64'h5, 1, 2'd0, "R2 scale x1");
                drive(1, 2'b00, 32'h0, 1, 64'h200, 1, 64'h5, 1, 2'd1, "R2 scale x2");
                drive(1, 2'b00, 32'h3, 1, 64'h200, 1, 64'h5, 1, 2'd3, "R2 scale x8 + disp");
                // R3: scaled index without base
                drive(1, 2'b00, 32'h40, 0, 64'hFFFF, 1, 64'h3, 1, 2'd2, "R3 index no base");
                // R5: index present, no explicit scale
                drive(1, 2'b00, 32'h0, 1, 64'h200, 1, 64'h7, 0, 2'd3, "R5 default scale 1");
                // R4: index absent, stray index value and scale ignored
                drive(1, 2'b00, 32'h0, 1, 64'h300, 0, 64'h1234_5678, 1, 2'd3, "R4 index ignored");
                // R6: negative displacements
                drive(1, 2'b00, -32'sd16, 1, 64'h200, 1, 64'h3, 1, 2'd2, "R6 disp -16");
                drive(1, 2'b00, -32'sd4, 1, 64'h200, 0, 64'h0, 0, 2'd0, "R6 disp -4");
                // R1: wrap modulo 2^64
                drive(1, 2'b00, 32'h1, 1, 64'hFFFF_FFFF_FFFF_FFFF, 0, 64'h0, 0, 2'd0, "R1 wrap");
                // R8: 64-bit arithmetic mode
                drive(1, 2'b01, 32'd80, 1, 64'h0000_0089_1234_4000, 1, 64'h20, 1, 2'd1, "R8 lea64");
                // R9: 32-bit arithmetic mode clears upper half
                drive(1, 2'b10, 32'h0, 1, 64'h0000_0089_1234_4000, 1, 64'h20, 1, 2'd0, "R9 lea32");
                drive(1, 2'b10, -32'sd8, 1, 64'hFFFF_FFFF_FF00_0300, 0, 64'h0, 0, 2'd0, "R9 lea32 neg");
                // R10: idle cycle
                drive(0, 2'b00, 32'h55, 1, 64'h1, 1, 64'h1, 1, 2'd1, "R10 idle");
                // R11: reserved mode
                drive(1, 2'b11, 32'h77, 1, 64'h100, 0, 64'h0, 0, 2'd0, "R11 reserved");
                // R7 R8 R9: back-to-back alternating modes
                drive(1, 2'b01, 32'h10, 1, 64'h1000, 0, 64'h0, 0, 2'd0, "R8 back-to-back");
                drive(1, 2'b00, 32'h20, 1, 64'h2000, 0, 64'h0, 0, 2'd0, "R7 back-to-back");
                drive(1, 2'b10, 32'h30, 1, 64'hAAAA_0000_3000, 0, 64'h0, 0, 2'd0, "R9 back-to-back");
                drive(0, 2'b00, 32'h0, 0, 64'h0, 0, 64'h0, 0, 2'd0, "R10 drain");
                repeat (3) @(posedge clk);
                #3;
            end
            begin
                repeat (2000) @(posedge clk);
                errors++;
                checks++;
                $display("FAIL watchdog: run did not finish, got timeout, expected completion");
            end
        join_any
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule